// File: doc/BRIEF.md
# Linear Frequency Ramp Generator

This block produces a 32-bit frequency tuning word for a phase accumulator. The word sweeps linearly between a programmed floor and a programmed ceiling. Software programs six values through a small write port: the two limits, the size of an upward step, the size of a downward step, and the spacing in clock cycles between upward steps and between downward steps.

While the block is enabled, an external direction input picks the sweep direction, and an external hold input freezes the sweep. A registered flag reports that the ramp has arrived at a limit. A step that would pass a limit stops on the limit, so the word never wraps. While the block is disabled, the word is parked on the floor value and the step timer is cleared, so every sweep starts from a known point.

Top module: `freq_ramp_gen`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_wdata` at the next rising edge into the register chosen by `cfg_addr`. Address 0 is the floor, 1 the ceiling, 2 the upward step, 3 the downward step, 4 the upward interval and 5 the downward interval. The two intervals take the low `IW` bits of the data. Every register resets to 0, and addresses 6 and 7 are ignored.
- R2: During reset, and at every edge with `run` low, `ftw` takes the stored floor value, the step timer clears and `at_limit` goes to 0.
- R3: With `run` high, `hold` low and `dir_up` high, `ftw` rises by the upward step at every Nth enabled edge, where N is the upward interval. An interval of 0 acts as 1. The first step lands on the Nth edge after the timer is cleared.
- R4: With `dir_up` low, `ftw` falls by the downward step at every Mth edge, where M is the downward interval, and an interval of 0 acts as 1.
- R5: A step that would reach or pass a limit leaves `ftw` exactly on that limit, with no wrap across the 32-bit range.
- R6: `at_limit` is set by a step that ends on a limit, including a step that stays on a limit. It is cleared by the first step that ends strictly between the limits.
- R7: While `hold` is high, neither `ftw` nor the step timer changes.
- R8: A change of `dir_up` takes effect at a step boundary. The timer keeps its count and is compared with the interval of the new direction. If the count already reaches that interval, the step is taken at the next edge. No step is skipped or repeated.
- R9: A step size of 0 leaves `ftw` unchanged while it is strictly between the limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | W | Register write data |
| run | input | 1 | Ramp enable; low parks the word on the floor |
| dir_up | input | 1 | Sweep direction, high for upward |
| hold | input | 1 | Freezes the sweep while high |
| at_limit | output | 1 | High once the ramp has arrived at a limit |
| ftw | output | W | Frequency tuning word |

## Verification
The hardest case to bring about is a direction change in the middle of an interval, when the elapsed count already exceeds the interval of the new direction. The stimulus gets there by choosing a long upward interval and a one-cycle downward interval. It lets the upward timer run partway, then flips `dir_up` and expects an immediate downward step. The same sequence then walks the word down into the floor clamp. Arrival at the ceiling is reached both from a step that lands exactly on the limit and from steps near the top of the 32-bit range that would otherwise wrap.

// File: rtl/freq_ramp_gen.sv
module freq_ramp_gen #(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [W-1:0]  cfg_wdata,
  input  logic          run,
  input  logic          dir_up,
  input  logic          hold,
  output logic          at_limit,
  output logic [W-1:0]  ftw
);

  logic [W-1:0]  lo_q, hi_q, stp_up_q, stp_dn_q;
  logic [IW-1:0] int_up_q, int_dn_q, cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q     <= '0;
      hi_q     <= '0;
      stp_up_q <= '0;
      stp_dn_q <= '0;
      int_up_q <= '0;
      int_dn_q <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        3'd0: lo_q     <= cfg_wdata;
        3'd1: hi_q     <= cfg_wdata;
        3'd2: stp_up_q <= cfg_wdata;
        3'd3: stp_dn_q <= cfg_wdata;
        3'd4: int_up_q <= cfg_wdata[IW-1:0];
        3'd5: int_dn_q <= cfg_wdata[IW-1:0];
        default: ;
      endcase
    end
  end

  logic [IW-1:0] int_sel;
  logic          step_now;
  logic          up_hit, dn_hit;
  logic [W-1:0]  nxt;

  assign int_sel  = dir_up ? int_up_q : int_dn_q;
  assign step_now = (int_sel == '0) || (cnt_q >= int_sel - IW'(1));
  assign up_hit   = (ftw >= hi_q) || ((hi_q - ftw) <= stp_up_q);
  assign dn_hit   = (ftw <= lo_q) || ((ftw - lo_q) <= stp_dn_q);

  always_comb begin
    if (dir_up) nxt = up_hit ? hi_q : ftw + stp_up_q;
    else        nxt = dn_hit ? lo_q : ftw - stp_dn_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ftw      <= '0;
      cnt_q    <= '0;
      at_limit <= 1'b0;
    end else if (!run) begin
      ftw      <= lo_q;
      cnt_q    <= '0;
      at_limit <= 1'b0;
    end else if (!hold) begin
      if (step_now) begin
        ftw      <= nxt;
        cnt_q    <= '0;
        at_limit <= dir_up ? up_hit : dn_hit;
      end else begin
        cnt_q    <= cnt_q + IW'(1);
      end
    end
  end

endmodule

// File: rtl/freq_ramp_gen_chk.sv
module freq_ramp_gen_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_we,
  input logic         run,
  input logic         dir_up,
  input logic         hold,
  input logic         at_limit,
  input logic [W-1:0] ftw,
  input logic [W-1:0] lo_q,
  input logic [W-1:0] hi_q
);

  AST_DISABLED_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cfg_we) |=> (ftw == $past(lo_q) && !at_limit)); // R2

  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hold) |=> (ftw == $past(ftw))); // R7

  AST_UP_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !hold && dir_up && ftw <= hi_q) |=> (ftw >= $past(ftw))); // R3

  AST_DN_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !hold && !dir_up && ftw >= lo_q) |=> (ftw <= $past(ftw))); // R4

  AST_UP_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cfg_we && dir_up && ftw <= hi_q) |=> (ftw <= $past(hi_q))); // R5

  AST_FLAG_ON_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(at_limit) && !$past(cfg_we)) |-> (ftw == hi_q || ftw == lo_q)); // R6

endmodule

bind freq_ramp_gen freq_ramp_gen_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .run(run), .dir_up(dir_up),
  .hold(hold), .at_limit(at_limit), .ftw(ftw), .lo_q(lo_q), .hi_q(hi_q)
);

// File: tb/tb_freq_ramp_gen.sv
module tb_freq_ramp_gen;
  localparam int W = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [W-1:0] cfg_wdata = '0;
  logic run = 1'b0, dir_up = 1'b1, hold = 1'b0;
  logic at_limit;
  logic [W-1:0] ftw;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  freq_ramp_gen dut (.*);

  typedef struct packed {
    logic [31:0] lo, hi, su, sd;
    logic [15:0] iu, id;
    logic        dir;
    logic [7:0]  cyc;
    logic [31:0] exp_ftw;
    logic        exp_flag;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'd100, 32'd1000, 32'd10, 32'd5, 16'd1, 16'd1, 1'b1, 8'd5, 32'd150, 1'b0},
    '{32'd100, 32'd1000, 32'd10, 32'd5, 16'd4, 16'd1, 1'b1, 8'd12, 32'd130, 1'b0},
    '{32'd100, 32'd125, 32'd10, 32'd5, 16'd1, 16'd1, 1'b1, 8'd3, 32'd125, 1'b1},
    '{32'd100, 32'd125, 32'd10, 32'd5, 16'd1, 16'd1, 1'b1, 8'd10, 32'd125, 1'b1},
    '{32'd100, 32'd1000, 32'd10, 32'd5, 16'd1, 16'd1, 1'b0, 8'd2, 32'd100, 1'b1},
    '{32'hFFFF_FF00, 32'hFFFF_FFFF, 32'h80, 32'd1, 16'd1, 16'd1, 1'b1, 8'd2, 32'hFFFF_FFFF, 1'b1},
    '{32'd100, 32'd1000, 32'd0, 32'd0, 16'd1, 16'd1, 1'b1, 8'd5, 32'd100, 1'b0},
    '{32'd0, 32'd1000, 32'd7, 32'd5, 16'd0, 16'd0, 1'b1, 8'd3, 32'd21, 1'b0}
  };
  localparam string VTAG [8] = '{"R3", "R3", "R5", "R6", "R4", "R5", "R9", "R3"};

  task automatic chk(string tag, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [W-1:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic edges(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    edges(2);
    chk("R2 reset ftw", ftw, 0);
    chk("R2 reset flag", {31'd0, at_limit}, 0);
    rst_n = 1'b1;
    edges(1);

    for (int i = 0; i < 8; i++) begin
      run = 1'b0;
      wr(3'd0, VECS[i].lo); wr(3'd1, VECS[i].hi);
      wr(3'd2, VECS[i].su); wr(3'd3, VECS[i].sd);
      wr(3'd4, 32'(VECS[i].iu)); wr(3'd5, 32'(VECS[i].id));
      edges(1);
      chk("R1 floor loaded", ftw, VECS[i].lo);
      dir_up = VECS[i].dir; run = 1'b1;
      edges(int'(VECS[i].cyc));
      chk({VTAG[i], " ftw"}, ftw, VECS[i].exp_ftw);
      chk({VTAG[i], " flag"}, {31'd0, at_limit}, {31'd0, VECS[i].exp_flag});
    end

    // R1: unused address ignored
    run = 1'b0;
    wr(3'd0, 0); wr(3'd1, 50); wr(3'd2, 10); wr(3'd3, 3);
    wr(3'd4, 1); wr(3'd5, 2); wr(3'd6, 32'd999); wr(3'd7, 32'd777);
    edges(1);
    chk("R1 addr6/7 ignored floor", ftw, 0);
    dir_up = 1'b1; run = 1'b1;
    edges(5);
    chk("R1 map ftw", ftw, 50);
    chk("R6 set at ceiling", {31'd0, at_limit}, 1);
    dir_up = 1'b0;
    edges(1);
    chk("R8 no early step", ftw, 50);
    edges(1);
    chk("R4 down step", ftw, 47);
    chk("R6 cleared leaving", {31'd0, at_limit}, 0);
    hold = 1'b1;
    edges(5);
    chk("R7 hold ftw", ftw, 47);
    hold = 1'b0;
    edges(1);
    chk("R7 timer frozen", ftw, 47);
    edges(1);
    chk("R4 resume", ftw, 44);

    // R8: mid-interval change with count past new interval
    run = 1'b0;
    wr(3'd4, 4); wr(3'd5, 1);
    edges(1);
    dir_up = 1'b1; run = 1'b1;
    edges(4);
    chk("R3 interval 4", ftw, 10);
    edges(2);
    chk("R8 mid interval", ftw, 10);
    dir_up = 1'b0;
    edges(1);
    chk("R8 immediate step", ftw, 7);
    edges(3);
    chk("R5 floor clamp", ftw, 0);
    chk("R6 at floor", {31'd0, at_limit}, 1);

    // R2: disable parks and clears timer
    run = 1'b0;
    wr(3'd0, 20);
    edges(1);
    chk("R2 parked", ftw, 20);
    chk("R2 flag clear", {31'd0, at_limit}, 0);
    dir_up = 1'b1; run = 1'b1;
    edges(3);
    chk("R2 timer cleared", ftw, 20);
    edges(1);
    chk("R2 first step", ftw, 30);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule